// File: doc/BRIEF.md
# Parallel-Port Block Transfer Engine

This block sits on the host side of a parallel-port link to a disk bridge and moves a burst of bytes between a stream interface and the bridge's disk data register. A transfer is requested with a start pulse, together with a direction, a byte count and a port mode. In nibble mode each byte is read back as two 4-bit status samples. In byte mode the whole byte is read from the bidirectional data lines.

Once started, the engine writes a fixed command preamble to the port's data and control registers. It then moves the bytes one at a time. On reads it presents each assembled byte on a valid/ready source. On writes it takes each byte from a valid/ready sink. The engine performs at most one port register write per clock. Each write is marked by a one-cycle strobe that names the register written. A one-cycle done pulse closes every transfer.

Top module: `pp_blk_engine`

## Requirements
- R1: After synchronous reset the data register output is 0x00 and the control output is 0x04. Busy, done, both write strobes, `rd_valid_o` and `wr_ready_o` are all low.
- R2: A transfer opens with 24 port writes, one per cycle, in this order. Data 0x81, then control 0x05, 0x0D, 0x05, 0x04. The mode byte, then control 0x05, 0x07, 0x05, 0x04. Data 0x82, then control 0x05, 0x0D, 0x05, 0x04. Control 0x06, 0x04, 0x06, 0x04. Data 0x20, then control 0x05, 0x0D, 0x05, 0x04.
- R3: The mode byte written in the preamble is 0x09 in nibble mode (`byte_mode_i`=0) and 0x19 in byte mode (`byte_mode_i`=1).
- R4: A nibble-mode read writes control 0x06, 0x04, 0x06, 0x04 for each byte. The status input is sampled while control is 0x06, first for the low half and then for the high half. The byte is built as follows: bits 2:0 = low[5:3], bit 3 = NOT low[7], bits 6:4 = high[5:3], bit 7 = NOT high[7]. Bytes leave in the order they were read.
- R5: A byte-mode read writes data 0x00 once after the preamble. For each byte it then writes control 0x26 and, in the very next cycle, control 0x24, capturing the data input while control is 0x26. After the last byte it writes control 0x04.
- R6: A write (`dir_i`=1) in either mode does the following for each byte: control 0x05, then data = the byte, then control 0x07. After the last byte it writes control 0x05 and then 0x04. Bytes go out in the order they were accepted.
- R7: While `rd_valid_o` is high and `rd_ready_i` is low, the next cycle keeps `rd_valid_o` high with `rd_data_o` unchanged, and no port write happens.
- R8: The engine asks for a write byte only through `wr_ready_o`. It makes no port write in the cycle after one in which `wr_ready_o` is high and `wr_valid_i` is low.
- R9: A count of zero ends the transfer right after the preamble. Done rises in the same cycle as the final 0x04 control write, and no data phase follows.
- R10: Done is a one-cycle pulse, raised once per transfer. Busy is low from the done cycle onward. A port write seen while busy is low falls in a done cycle.
- R11: Start is ignored while busy. A start presented in the done cycle is accepted, and busy is high in the following cycle.
- R12: `rd_valid_o` and `wr_ready_o` are never high together, and at most one write strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a transfer (sampled when idle) |
| dir_i | input | 1 | 0 = read from bridge, 1 = write to bridge |
| byte_mode_i | input | 1 | 0 = nibble mode, 1 = byte mode |
| count_i | input | CNT_W | Number of bytes to move |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| pp_data_o | output | 8 | Port data register value |
| pp_ctrl_o | output | 8 | Port control register value |
| pp_data_wr_o | output | 1 | Data register written this cycle |
| pp_ctrl_wr_o | output | 1 | Control register written this cycle |
| pp_status_i | input | 8 | Port status lines |
| pp_data_i | input | 8 | Port data lines as read back |
| rd_valid_o | output | 1 | Read byte available |
| rd_data_o | output | 8 | Read byte |
| rd_ready_i | input | 1 | Read byte taken |
| wr_valid_i | input | 1 | Write byte offered |
| wr_data_i | input | 8 | Write byte |
| wr_ready_o | output | 1 | Engine accepts write byte |

## Verification
Two functions can meet in one clock: the done pulse that ends a transfer and the acceptance of the next start. The bench raises start in the same cycle that done is seen. It then expects busy high one cycle later and the second transfer's preamble to follow without a gap in the write trace. A second overlap is a start pulse during a running transfer, which must leave that transfer's write trace and byte order untouched. Every port write, and every byte at the stream interfaces, is compared with a queue that a behavioural model fills from the requirements. Random stalls on both stream sides exercise the hold rules.

// File: rtl/pp_blk_pkg.sv
package pp_blk_pkg;

    localparam int          PRE_LEN  = 24;
    localparam int          PRE_IW   = $clog2(PRE_LEN);
    localparam logic [PRE_IW-1:0] PRE_LAST = PRE_IW'(PRE_LEN - 1);

    localparam logic [7:0] CTL_IDLE   = 8'h04;
    localparam logic [7:0] CTL_STB_LO = 8'h05;
    localparam logic [7:0] CTL_STB_HI = 8'h07;
    localparam logic [7:0] CTL_SEL    = 8'h0D;
    localparam logic [7:0] CTL_SMP    = 8'h06;
    localparam logic [7:0] CTL_RD_HI  = 8'h26;
    localparam logic [7:0] CTL_RD_LO  = 8'h24;

    localparam logic [7:0] CMD_OPEN   = 8'h81;
    localparam logic [7:0] CMD_BLOCK  = 8'h82;
    localparam logic [7:0] CMD_DATA   = 8'h20;
    localparam logic [7:0] MODE_NIB   = 8'h09;
    localparam logic [7:0] MODE_BYTE  = 8'h19;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_DATA = 2'd1,
        ACT_CTRL = 2'd2
    } act_kind_e;

    typedef struct packed {
        act_kind_e  kind;
        logic [7:0] val;
    } port_act_t;

    typedef enum logic [1:0] {
        PAT_SEL = 2'd0,
        PAT_STB = 2'd1,
        PAT_SMP = 2'd2
    } pat_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PRE, S_RD_DZ, S_NR_H1, S_NR_L1, S_NR_H2, S_NR_L2,
        S_BR_H, S_BR_L, S_RD_OUT, S_BR_END,
        S_WR_WAIT, S_WR_DAT, S_WR_STB, S_WR_E1, S_WR_E2
    } st_e;

    function automatic port_act_t mk_data(input logic [7:0] v);
        port_act_t a;
        a.kind = ACT_DATA;
        a.val  = v;
        return a;
    endfunction

    function automatic port_act_t mk_ctrl(input logic [7:0] v);
        port_act_t a;
        a.kind = ACT_CTRL;
        a.val  = v;
        return a;
    endfunction

    // Four-step control pulse shapes; the last step always returns to idle.
    function automatic logic [7:0] pulse_step(input pat_e pat, input logic [1:0] pos);
        logic [7:0] v;
        if (pos == 2'd3) begin
            v = CTL_IDLE;
        end else if (pos == 2'd1) begin
            case (pat)
                PAT_SEL: v = CTL_SEL;
                PAT_STB: v = CTL_STB_HI;
                default: v = CTL_IDLE;
            endcase
        end else begin
            v = (pat == PAT_SMP) ? CTL_SMP : CTL_STB_LO;
        end
        return v;
    endfunction

    function automatic port_act_t preamble_act(input logic [PRE_IW-1:0] idx,
                                               input logic byte_mode);
        port_act_t        a;
        logic [PRE_IW-1:0] off;
        a = mk_ctrl(CTL_IDLE);
        if (idx == 5'd0) begin
            a = mk_data(CMD_OPEN);
        end else if (idx <= 5'd4) begin
            off = idx - 5'd1;
            a   = mk_ctrl(pulse_step(PAT_SEL, off[1:0]));
        end else if (idx == 5'd5) begin
            a = mk_data(byte_mode ? MODE_BYTE : MODE_NIB);
        end else if (idx <= 5'd9) begin
            off = idx - 5'd6;
            a   = mk_ctrl(pulse_step(PAT_STB, off[1:0]));
        end else if (idx == 5'd10) begin
            a = mk_data(CMD_BLOCK);
        end else if (idx <= 5'd14) begin
            off = idx - 5'd11;
            a   = mk_ctrl(pulse_step(PAT_SEL, off[1:0]));
        end else if (idx <= 5'd18) begin
            off = idx - 5'd15;
            a   = mk_ctrl(pulse_step(PAT_SMP, off[1:0]));
        end else if (idx == 5'd19) begin
            a = mk_data(CMD_DATA);
        end else begin
            off = idx - 5'd20;
            a   = mk_ctrl(pulse_step(PAT_SEL, off[1:0]));
        end
        return a;
    endfunction

    // Rebuild one byte from two status samples (two bits arrive inverted).
    function automatic logic [7:0] nib_merge(input logic [7:0] lo, input logic [7:0] hi);
        return {~hi[7], hi[5:3], ~lo[7], lo[5:3]};
    endfunction

endpackage

// File: rtl/pp_blk_port.sv
module pp_blk_port
    import pp_blk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_act_t  act_i,
    output logic [7:0] data_o,
    output logic [7:0] ctrl_o,
    output logic       data_wr_o,
    output logic       ctrl_wr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o    <= 8'h00;
            ctrl_o    <= CTL_IDLE;
            data_wr_o <= 1'b0;
            ctrl_wr_o <= 1'b0;
        end else begin
            data_wr_o <= (act_i.kind == ACT_DATA);
            ctrl_wr_o <= (act_i.kind == ACT_CTRL);
            if (act_i.kind == ACT_DATA) data_o <= act_i.val;
            if (act_i.kind == ACT_CTRL) ctrl_o <= act_i.val;
        end
    end
endmodule

// File: rtl/pp_blk_count.sv
module pp_blk_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o,
    output logic             zero_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= load_val_i;
        end else if (dec_i && (left_q != '0)) begin
            left_q <= left_q - ONE;
        end
    end

    assign last_o = (left_q == ONE);
    assign zero_o = (left_q == '0);
endmodule

// File: rtl/pp_blk_rx.sv
module pp_blk_rx
    import pp_blk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_lo_i,
    input  logic       cap_hi_i,
    input  logic       cap_byte_i,
    input  logic [7:0] status_i,
    input  logic [7:0] data_i,
    output logic [7:0] byte_o
);
    logic [7:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= 8'h00;
            byte_o <= 8'h00;
        end else begin
            if (cap_lo_i)   lo_q   <= status_i;
            if (cap_hi_i)   byte_o <= nib_merge(lo_q, status_i);
            if (cap_byte_i) byte_o <= data_i;
        end
    end
endmodule

// File: rtl/pp_blk_fsm.sv
module pp_blk_fsm
    import pp_blk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       dir_i,
    input  logic       byte_mode_i,
    input  logic       cnt_last_i,
    input  logic       cnt_zero_i,
    input  logic       rd_ready_i,
    input  logic       wr_valid_i,
    input  logic [7:0] wr_data_i,
    output port_act_t  act_o,
    output logic       cnt_load_o,
    output logic       cnt_dec_o,
    output logic       cap_lo_o,
    output logic       cap_hi_o,
    output logic       cap_byte_o,
    output logic       rd_valid_o,
    output logic       wr_ready_o,
    output logic       busy_o,
    output logic       done_o
);
    st_e               st_q, st_d;
    logic [PRE_IW-1:0] pre_q, pre_d;
    logic              dir_q, bmode_q, wsave_q;
    logic [7:0]        wbyte_q;
    logic              latch, done_d;

    always_comb begin
        st_d       = st_q;
        pre_d      = pre_q;
        act_o      = '{kind: ACT_NONE, val: 8'h00};
        cnt_load_o = 1'b0;
        cnt_dec_o  = 1'b0;
        cap_lo_o   = 1'b0;
        cap_hi_o   = 1'b0;
        cap_byte_o = 1'b0;
        latch      = 1'b0;
        done_d     = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (start_i) begin
                    st_d       = S_PRE;
                    pre_d      = '0;
                    latch      = 1'b1;
                    cnt_load_o = 1'b1;
                end
            end
            S_PRE: begin
                act_o = preamble_act(pre_q, bmode_q);
                pre_d = pre_q + 1'b1;
                if (pre_q == PRE_LAST) begin
                    if (cnt_zero_i) begin
                        st_d   = S_IDLE;
                        done_d = 1'b1;
                    end else if (dir_q) begin
                        st_d = S_WR_WAIT;
                    end else if (bmode_q) begin
                        st_d = S_RD_DZ;
                    end else begin
                        st_d = S_NR_H1;
                    end
                end
            end
            S_RD_DZ: begin
                act_o = mk_data(8'h00);
                st_d  = S_BR_H;
            end
            S_NR_H1: begin
                act_o = mk_ctrl(CTL_SMP);
                st_d  = S_NR_L1;
            end
            S_NR_L1: begin
                act_o    = mk_ctrl(CTL_IDLE);
                cap_lo_o = 1'b1;
                st_d     = S_NR_H2;
            end
            S_NR_H2: begin
                act_o = mk_ctrl(CTL_SMP);
                st_d  = S_NR_L2;
            end
            S_NR_L2: begin
                act_o    = mk_ctrl(CTL_IDLE);
                cap_hi_o = 1'b1;
                st_d     = S_RD_OUT;
            end
            S_BR_H: begin
                act_o = mk_ctrl(CTL_RD_HI);
                st_d  = S_BR_L;
            end
            S_BR_L: begin
                act_o      = mk_ctrl(CTL_RD_LO);
                cap_byte_o = 1'b1;
                st_d       = S_RD_OUT;
            end
            S_RD_OUT: begin
                if (rd_ready_i) begin
                    cnt_dec_o = 1'b1;
                    if (cnt_last_i) begin
                        if (bmode_q) begin
                            st_d = S_BR_END;
                        end else begin
                            st_d   = S_IDLE;
                            done_d = 1'b1;
                        end
                    end else begin
                        st_d = bmode_q ? S_BR_H : S_NR_H1;
                    end
                end
            end
            S_BR_END: begin
                act_o  = mk_ctrl(CTL_IDLE);
                st_d   = S_IDLE;
                done_d = 1'b1;
            end
            S_WR_WAIT: begin
                if (wr_valid_i) begin
                    act_o = mk_ctrl(CTL_STB_LO);
                    st_d  = S_WR_DAT;
                end
            end
            S_WR_DAT: begin
                act_o = mk_data(wbyte_q);
                st_d  = S_WR_STB;
            end
            S_WR_STB: begin
                act_o     = mk_ctrl(CTL_STB_HI);
                cnt_dec_o = 1'b1;
                st_d      = cnt_last_i ? S_WR_E1 : S_WR_WAIT;
            end
            S_WR_E1: begin
                act_o = mk_ctrl(CTL_STB_LO);
                st_d  = S_WR_E2;
            end
            S_WR_E2: begin
                act_o  = mk_ctrl(CTL_IDLE);
                st_d   = S_IDLE;
                done_d = 1'b1;
            end
            default: st_d = S_IDLE;
        endcase
    end

    assign wsave_q = (st_q == S_WR_WAIT) && wr_valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            pre_q   <= '0;
            dir_q   <= 1'b0;
            bmode_q <= 1'b0;
            wbyte_q <= 8'h00;
            done_o  <= 1'b0;
        end else begin
            st_q   <= st_d;
            pre_q  <= pre_d;
            done_o <= done_d;
            if (latch) begin
                dir_q   <= dir_i;
                bmode_q <= byte_mode_i;
            end
            if (wsave_q) wbyte_q <= wr_data_i;
        end
    end

    assign rd_valid_o = (st_q == S_RD_OUT);
    assign wr_ready_o = (st_q == S_WR_WAIT);
    assign busy_o     = (st_q != S_IDLE);
endmodule

// File: rtl/pp_blk_engine.sv
module pp_blk_engine
    import pp_blk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic             byte_mode_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [7:0]       pp_data_o,
    output logic [7:0]       pp_ctrl_o,
    output logic             pp_data_wr_o,
    output logic             pp_ctrl_wr_o,
    input  logic [7:0]       pp_status_i,
    input  logic [7:0]       pp_data_i,
    output logic             rd_valid_o,
    output logic [7:0]       rd_data_o,
    input  logic             rd_ready_i,
    input  logic             wr_valid_i,
    input  logic [7:0]       wr_data_i,
    output logic             wr_ready_o
);
    port_act_t act;
    logic      cnt_load, cnt_dec, cnt_last, cnt_zero;
    logic      cap_lo, cap_hi, cap_byte;

    pp_blk_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .dir_i       (dir_i),
        .byte_mode_i (byte_mode_i),
        .cnt_last_i  (cnt_last),
        .cnt_zero_i  (cnt_zero),
        .rd_ready_i  (rd_ready_i),
        .wr_valid_i  (wr_valid_i),
        .wr_data_i   (wr_data_i),
        .act_o       (act),
        .cnt_load_o  (cnt_load),
        .cnt_dec_o   (cnt_dec),
        .cap_lo_o    (cap_lo),
        .cap_hi_o    (cap_hi),
        .cap_byte_o  (cap_byte),
        .rd_valid_o  (rd_valid_o),
        .wr_ready_o  (wr_ready_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    pp_blk_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cnt_load),
        .load_val_i (count_i),
        .dec_i      (cnt_dec),
        .last_o     (cnt_last),
        .zero_o     (cnt_zero)
    );

    pp_blk_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .cap_lo_i   (cap_lo),
        .cap_hi_i   (cap_hi),
        .cap_byte_i (cap_byte),
        .status_i   (pp_status_i),
        .data_i     (pp_data_i),
        .byte_o     (rd_data_o)
    );

    pp_blk_port u_port (
        .clk       (clk),
        .rst       (rst),
        .act_i     (act),
        .data_o    (pp_data_o),
        .ctrl_o    (pp_ctrl_o),
        .data_wr_o (pp_data_wr_o),
        .ctrl_wr_o (pp_ctrl_wr_o)
    );
endmodule

// File: rtl/pp_blk_chk.sv
module pp_blk_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy_o,
    input logic       done_o,
    input logic [7:0] pp_ctrl_o,
    input logic       pp_data_wr_o,
    input logic       pp_ctrl_wr_o,
    input logic       rd_valid_o,
    input logic [7:0] rd_data_o,
    input logic       rd_ready_i,
    input logic       wr_valid_i,
    input logic       wr_ready_o
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_idle_write_R10: assert property (@(posedge clk) disable iff (rst)
        ((pp_data_wr_o || pp_ctrl_wr_o) && !busy_o) |-> done_o);

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && !rd_ready_i) |=>
            (rd_valid_o && $stable(rd_data_o) && !pp_data_wr_o && !pp_ctrl_wr_o));

    assert_wr_wait_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_ready_o && !wr_valid_i) |=> (!pp_data_wr_o && !pp_ctrl_wr_o));

    assert_byte_rd_pair_R5: assert property (@(posedge clk) disable iff (rst)
        (pp_ctrl_wr_o && pp_ctrl_o == 8'h26) |=> (pp_ctrl_wr_o && pp_ctrl_o == 8'h24));

    assert_stream_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid_o && wr_ready_o));

    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pp_data_wr_o, pp_ctrl_wr_o}));
endmodule

bind pp_blk_engine pp_blk_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pp_ctrl_o    (pp_ctrl_o),
    .pp_data_wr_o (pp_data_wr_o),
    .pp_ctrl_wr_o (pp_ctrl_wr_o),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .rd_ready_i   (rd_ready_i),
    .wr_valid_i   (wr_valid_i),
    .wr_ready_o   (wr_ready_o)
);

// File: tb/pp_blk_engine_bench.sv
module pp_blk_engine_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0, dir_i = 1'b0, byte_mode_i = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic             busy_o, done_o;
    logic [7:0]       pp_data_o, pp_ctrl_o;
    logic             pp_data_wr_o, pp_ctrl_wr_o;
    logic [7:0]       pp_status_i = 8'h00, pp_data_i = 8'h00;
    logic             rd_valid_o, rd_ready_i = 1'b0;
    logic [7:0]       rd_data_o;
    logic             wr_valid_i = 1'b0, wr_ready_o;
    logic [7:0]       wr_data_i = 8'h00;

    always #5 clk = ~clk;

    pp_blk_engine #(.CNT_W(CNT_W)) u_pp_blk_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i),
        .byte_mode_i(byte_mode_i), .count_i(count_i), .busy_o(busy_o), .done_o(done_o),
        .pp_data_o(pp_data_o), .pp_ctrl_o(pp_ctrl_o), .pp_data_wr_o(pp_data_wr_o),
        .pp_ctrl_wr_o(pp_ctrl_wr_o), .pp_status_i(pp_status_i), .pp_data_i(pp_data_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_ready_i(rd_ready_i),
        .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o)
    );

    int checks = 0, errors = 0, cyc = 0, dones = 0, launched = 0;
    logic [8:0] exp_ev[$];
    string      exp_tag[$];
    logic [7:0] exp_rd[$];
    logic [7:0] dev_rd[$];
    logic [7:0] src_wr[$];
    string      rd_tag = "R4";
    bit         nib_phase = 1'b0, hs_pend = 1'b0, stall_prev = 1'b0;
    logic [7:0] stall_data = 8'h00, eb;
    logic [8:0] got, e;
    string      t;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Status value whose scrambled bits carry one half of byte b.
    function automatic logic [7:0] enc_nib(input logic [7:0] b, input bit hi);
        logic [7:0] s;
        s = 8'($urandom);
        if (!hi) begin s[7] = ~b[3]; s[5:3] = b[2:0]; end
        else     begin s[7] = ~b[7]; s[5:3] = b[6:4]; end
        return s;
    endfunction

    // Reference monitor and stream partners, evaluated every clock.
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                finish_run();
            end
            if (done_o) dones++;
            if (pp_data_wr_o && pp_ctrl_wr_o) begin
                chk(1'b0, "R12", "two strobes in one cycle", 1, 0);
            end else if (pp_data_wr_o || pp_ctrl_wr_o) begin
                got = {pp_ctrl_wr_o, pp_ctrl_wr_o ? pp_ctrl_o : pp_data_o};
                if (exp_ev.size() == 0) begin
                    chk(1'b0, "R10", "port write outside a transfer", int'(got), 0);
                end else begin
                    e = exp_ev.pop_front();
                    t = exp_tag.pop_front();
                    chk(got == e, t, "port write trace", int'(got), int'(e));
                    if (t == "R4" && got == 9'h106 && dev_rd.size() > 0) begin
                        pp_status_i = enc_nib(dev_rd[0], nib_phase);
                        if (nib_phase) void'(dev_rd.pop_front());
                        nib_phase = ~nib_phase;
                    end
                    if (t == "R5" && got == 9'h126 && dev_rd.size() > 0)
                        pp_data_i = dev_rd.pop_front();
                end
            end
            if (stall_prev)
                chk(rd_valid_o && rd_data_o == stall_data, "R7", "stalled byte held",
                    int'(rd_data_o), int'(stall_data));
            rd_ready_i = ($urandom % 4) != 0;
            if (rd_valid_o && rd_ready_i) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, rd_tag, "extra read byte", int'(rd_data_o), 0);
                end else begin
                    eb = exp_rd.pop_front();
                    chk(rd_data_o == eb, rd_tag, "read byte order", int'(rd_data_o), int'(eb));
                end
            end
            stall_prev = rd_valid_o && !rd_ready_i;
            stall_data = rd_data_o;
            if (hs_pend) begin
                void'(src_wr.pop_front());
                wr_valid_i = 1'b0;
            end
            if (!wr_valid_i && src_wr.size() > 0 && ($urandom % 3) != 0) wr_valid_i = 1'b1;
            wr_data_i = (src_wr.size() > 0) ? src_wr[0] : 8'h00;
            hs_pend   = wr_valid_i && wr_ready_o;
        end
    end

    task automatic ev(input bit c, input logic [7:0] v, input string tag);
        exp_ev.push_back({c, v});
        exp_tag.push_back(tag);
    endtask

    task automatic pulse_a();
        ev(1, 8'h05, "R2"); ev(1, 8'h0D, "R2"); ev(1, 8'h05, "R2"); ev(1, 8'h04, "R2");
    endtask

    task automatic launch(input bit dir, input bit bm, input int n);
        logic [7:0] b;
        ev(0, 8'h81, "R2"); pulse_a();
        ev(0, bm ? 8'h19 : 8'h09, "R3");
        ev(1, 8'h05, "R2"); ev(1, 8'h07, "R2"); ev(1, 8'h05, "R2"); ev(1, 8'h04, "R2");
        ev(0, 8'h82, "R2"); pulse_a();
        ev(1, 8'h06, "R2"); ev(1, 8'h04, "R2"); ev(1, 8'h06, "R2"); ev(1, 8'h04, "R2");
        ev(0, 8'h20, "R2"); pulse_a();
        rd_tag    = bm ? "R5" : "R4";
        nib_phase = 1'b0;
        if (!dir && bm && n > 0) ev(0, 8'h00, "R5");
        for (int k = 0; k < n; k++) begin
            b = 8'($urandom);
            if (k == 0) b = 8'h88;
            if (dir) begin
                src_wr.push_back(b);
                ev(1, 8'h05, "R6"); ev(0, b, "R6"); ev(1, 8'h07, "R6");
            end else begin
                exp_rd.push_back(b);
                dev_rd.push_back(b);
                if (bm) begin ev(1, 8'h26, "R5"); ev(1, 8'h24, "R5"); end
                else begin
                    ev(1, 8'h06, "R4"); ev(1, 8'h04, "R4");
                    ev(1, 8'h06, "R4"); ev(1, 8'h04, "R4");
                end
            end
        end
        if (n > 0 && dir) begin ev(1, 8'h05, "R6"); ev(1, 8'h04, "R6"); end
        if (n > 0 && !dir && bm) ev(1, 8'h04, "R5");
        start_i = 1'b1; dir_i = dir; byte_mode_i = bm; count_i = CNT_W'(n);
        launched++;
        @(negedge clk); #1;
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R11", "busy after accepted start", int'(busy_o), 1);
    endtask

    task automatic wait_done(input bit zero);
        int w;
        w = 0;
        forever begin
            @(negedge clk); #1;
            if (done_o) break;
            w++;
            if (w > 40000) begin
                errors++;
                $display("FAIL R10 watchdog: actual no done expected done");
                finish_run();
            end
        end
        chk(exp_ev.size() == 0, "R10", "writes left at done", exp_ev.size(), 0);
        chk(exp_rd.size() == 0 && src_wr.size() == 0, "R10", "bytes left at done",
            exp_rd.size() + src_wr.size(), 0);
        chk(busy_o == 1'b0, "R10", "busy at done", int'(busy_o), 0);
        if (zero)
            chk(pp_ctrl_wr_o && pp_ctrl_o == 8'h04, "R9", "done with last preamble write",
                int'({pp_ctrl_wr_o, pp_ctrl_o}), 9'h104);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk(pp_data_o == 8'h00, "R1", "data after reset", int'(pp_data_o), 0);
        chk(pp_ctrl_o == 8'h04, "R1", "control after reset", int'(pp_ctrl_o), 4);
        chk(!busy_o && !done_o, "R1", "busy/done after reset", int'({busy_o, done_o}), 0);
        chk(!pp_data_wr_o && !pp_ctrl_wr_o, "R1", "strobes after reset",
            int'({pp_data_wr_o, pp_ctrl_wr_o}), 0);
        chk(!rd_valid_o && !wr_ready_o, "R1", "stream after reset",
            int'({rd_valid_o, wr_ready_o}), 0);
        @(negedge clk); #1;

        // R4 nibble reads
        launch(0, 0, 1);   wait_done(0);
        launch(0, 0, 2);   wait_done(0);
        launch(0, 0, 512); wait_done(0);
        // R5 byte reads
        launch(0, 1, 1);   wait_done(0);
        launch(0, 1, 2);   wait_done(0);
        launch(0, 1, 512); wait_done(0);
        // R6 writes, both modes
        launch(1, 0, 1);   wait_done(0);
        launch(1, 0, 2);   wait_done(0);
        launch(1, 1, 1);   wait_done(0);
        launch(1, 1, 512); wait_done(0);
        // R9 zero count
        launch(0, 0, 0);   wait_done(1);
        launch(1, 1, 0);   wait_done(1);
        // R11 start ignored while busy
        launch(1, 1, 2);
        repeat (6) @(negedge clk);
        #1 start_i = 1'b1; dir_i = 1'b0; byte_mode_i = 1'b0; count_i = '0;
        @(negedge clk); #1 start_i = 1'b0;
        chk(busy_o == 1'b1, "R11", "still busy after ignored start", int'(busy_o), 1);
        wait_done(0);
        // R11 start in the done cycle
        launch(1, 0, 2);   wait_done(0);
        launch(0, 1, 2);   wait_done(0);
        launch(0, 0, 2);   wait_done(0);
        repeat (5) @(negedge clk);
        #1;
        chk(dones == launched, "R10", "one done per transfer", dones, launched);
        finish_run();
    end
endmodule